// File: doc/BRIEF.md
# Codec Digital Power Sequencer

This block brings the digital half of an audio codec out of power-down, and puts it back down, one control line at a time. It follows the dependency chain of the clocks and resets. Two request inputs drive it: one for playback (DAC path) and one for capture (ADC path). A shared front branch serves both paths. It parks the system clock source off the first serial interface. It then enables the interface clock, selects the PLL as that clock's source, releases the interface reset and opens the interface module clock gate. The last step of the shared branch turns on the system clock.

Each path then runs its own three-step branch: reset release, module clock gate, then the digital converter enable. Every step is followed by a programmable settle time of at least two cycles. Power-down walks the same steps backwards. The shared branch stays up while either path still holds a request. A request that arrives part-way through a power-down turns the sequence around from the step it has reached. A per-path ready flag reports a fully enabled path.

Top module: `codec_pwr_seq`

## Requirements
- R1: While reset is held and right after it: sysclk_src_o is 1, so interface 2 is selected. All enables and gates are 0, all active-low resets are 0 (held) and both ready flags are 0.
- R2: A request from the fully-off state raises the shared branch lines one step at a time. The order is: sysclk_src_o falls to 0 (interface 1 selected), then ifclk_en_o, pll_src_o, if_rst_no, if_gate_o and sysclk_en_o each go to 1. The first change lands on the first clock edge that samples the request, and step k lands (k-1)*W edges later.
- R3: After the shared branch is up, a playback request steps dac_rst_no, dac_gate_o and dac_en_o to 1, in that order, each W edges after the previous step.
- R4: A capture request steps adc_rst_no, adc_gate_o and adc_en_o the same way. When both paths are pending, the DAC branch completes before the ADC branch starts.
- R5: W equals step_wait_i when that value is 2 or more. Values of 0 and 1 behave as 2, so no two control changes happen on adjacent edges.
- R6: dac_en_o is 1 only while if_gate_o, sysclk_en_o and dac_gate_o are all 1. adc_en_o is 1 only while if_gate_o, sysclk_en_o and adc_gate_o are all 1.
- R7: Each ready flag equals its path's digital enable, delayed by one clock.
- R8: When a request drops, the lines it raised return in exact reverse order with the same W spacing. DAC steps come down before ADC steps, and the shared branch comes down last.
- R9: While one path stays requested, dropping the other path takes down only that path's three lines. The shared branch remains fully up.
- R10: A request that returns during a power-down reverses direction at the next step slot. The step that had been taken down comes back up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_req_i | input | 1 | Playback path requested |
| cap_req_i | input | 1 | Capture path requested |
| step_wait_i | input | 8 | Cycles between steps (values below 2 act as 2) |
| sysclk_src_o | output | 1 | System clock source: 0 = interface 1, 1 = interface 2 |
| ifclk_en_o | output | 1 | Interface clock enable |
| pll_src_o | output | 1 | Interface clock taken from the PLL |
| if_rst_no | output | 1 | Interface module reset, active low |
| if_gate_o | output | 1 | Interface module clock gate open |
| sysclk_en_o | output | 1 | System clock enable |
| dac_rst_no | output | 1 | DAC module reset, active low |
| dac_gate_o | output | 1 | DAC module clock gate open |
| dac_en_o | output | 1 | Digital DAC enable |
| adc_rst_no | output | 1 | ADC module reset, active low |
| adc_gate_o | output | 1 | ADC module clock gate open |
| adc_en_o | output | 1 | Digital ADC enable |
| dac_ready_o | output | 1 | DAC path ready |
| adc_ready_o | output | 1 | ADC path ready |

## Verification
A request change that meets an idle sequencer moves the first line on the very edge that samples it. Step k of a run is then due (k-1)*W edges later, where W is step_wait_i clamped to at least 2. A ready flag follows its enable one edge later. The bench changes requests just after a falling edge and compares all fourteen outputs after every falling edge. At each sample it computes the expected step count as n/W+1, where n is the number of edges since the change. It holds that count at the run length and maps it arithmetically onto the line order of each branch. The reversal case is sampled at the exact slot where the direction flips.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  localparam int SH_STEPS   = 6;
  localparam int PATH_STEPS = 3;
  localparam int NPATH      = 2;
  localparam int PATH_DAC   = 0;
  localparam int PATH_ADC   = 1;
  localparam int WAIT_W     = 8;
  localparam int MIN_WAIT   = 2;
endpackage

// File: rtl/codec_pwr_timer.sv
module codec_pwr_timer #(
  parameter int CNT_W    = 8,
  parameter int MIN_WAIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] wait_i,
  input  logic             fire_i,
  output logic             idle_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff;

  assign eff    = (wait_i < CNT_W'(MIN_WAIT)) ? CNT_W'(MIN_WAIT) : wait_i;
  assign idle_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (fire_i)            cnt_q <= eff - CNT_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_fire_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> idle_o);
endmodule

// File: rtl/codec_pwr_chain.sv
module codec_pwr_chain #(
  parameter  int DEPTH = 3,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [LW-1:0]    lvl_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [DEPTH-1:0] taps_o
);
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lvl_q <= '0;
    else if (up_i && !full_o)      lvl_q <= lvl_q + LW'(1);
    else if (dn_i && !empty_o)     lvl_q <= lvl_q - LW'(1);
  end

  assign lvl_o   = lvl_q;
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);

  // thermometer decode: step i is on once the level passes it
  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    assign taps_o[i] = (32'(lvl_q) > i);
  end

  assert_single_move_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_i && dn_i));
  assert_one_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ((lvl_q == $past(lvl_q) + LW'(1)) || (lvl_q == $past(lvl_q) - LW'(1))));
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              play_req_i,
  input  logic              cap_req_i,
  input  logic [WAIT_W-1:0] step_wait_i,
  output logic              sysclk_src_o,
  output logic              ifclk_en_o,
  output logic              pll_src_o,
  output logic              if_rst_no,
  output logic              if_gate_o,
  output logic              sysclk_en_o,
  output logic              dac_rst_no,
  output logic              dac_gate_o,
  output logic              dac_en_o,
  output logic              adc_rst_no,
  output logic              adc_gate_o,
  output logic              adc_en_o,
  output logic              dac_ready_o,
  output logic              adc_ready_o
);
  localparam int SH_LW = $clog2(SH_STEPS + 1);
  localparam int P_LW  = $clog2(PATH_STEPS + 1);

  logic                  idle, fire, want_sh, found;
  logic                  up_sh, dn_sh, sh_full, sh_empty;
  logic [SH_LW-1:0]      sh_lvl;
  logic [SH_STEPS-1:0]   sh_taps;
  logic [NPATH-1:0]      req, up_p, dn_p, p_full, p_empty, ready_q;
  logic [P_LW-1:0]       p_lvl  [NPATH];
  logic [PATH_STEPS-1:0] p_taps [NPATH];
  logic [SH_LW+NPATH*P_LW-1:0] state_vec;

  assign req[PATH_DAC] = play_req_i;
  assign req[PATH_ADC] = cap_req_i;
  assign want_sh       = |req;

  // one move per slot: power-up first, DAC before ADC, shared branch last on the way down
  always_comb begin
    up_sh = 1'b0;
    dn_sh = 1'b0;
    up_p  = '0;
    dn_p  = '0;
    found = 1'b0;
    if (idle) begin
      if (want_sh && !sh_full) begin
        up_sh = 1'b1;
        found = 1'b1;
      end
      for (int p = 0; p < NPATH; p++) begin
        if (!found && req[p] && sh_full && !p_full[p]) begin
          up_p[p] = 1'b1;
          found   = 1'b1;
        end
      end
      for (int p = 0; p < NPATH; p++) begin
        if (!found && !req[p] && !p_empty[p]) begin
          dn_p[p] = 1'b1;
          found   = 1'b1;
        end
      end
      if (!found && !want_sh && (&p_empty) && !sh_empty) dn_sh = 1'b1;
    end
  end

  assign fire = up_sh | dn_sh | (|up_p) | (|dn_p);

  codec_pwr_timer #(.CNT_W(WAIT_W), .MIN_WAIT(MIN_WAIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wait_i (step_wait_i),
    .fire_i (fire),
    .idle_o (idle)
  );

  codec_pwr_chain #(.DEPTH(SH_STEPS)) u_shared (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .up_i    (up_sh),
    .dn_i    (dn_sh),
    .lvl_o   (sh_lvl),
    .full_o  (sh_full),
    .empty_o (sh_empty),
    .taps_o  (sh_taps)
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    codec_pwr_chain #(.DEPTH(PATH_STEPS)) u_path (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .up_i    (up_p[g]),
      .dn_i    (dn_p[g]),
      .lvl_o   (p_lvl[g]),
      .full_o  (p_full[g]),
      .empty_o (p_empty[g]),
      .taps_o  (p_taps[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ready_q[g] <= 1'b0;
      else         ready_q[g] <= p_taps[g][PATH_STEPS-1];
    end
  end

  // source select low means interface 1
  assign sysclk_src_o = ~sh_taps[0];
  assign ifclk_en_o   = sh_taps[1];
  assign pll_src_o    = sh_taps[2];
  assign if_rst_no    = sh_taps[3];
  assign if_gate_o    = sh_taps[4];
  assign sysclk_en_o  = sh_taps[5];
  assign dac_rst_no   = p_taps[PATH_DAC][0];
  assign dac_gate_o   = p_taps[PATH_DAC][1];
  assign dac_en_o     = p_taps[PATH_DAC][2];
  assign adc_rst_no   = p_taps[PATH_ADC][0];
  assign adc_gate_o   = p_taps[PATH_ADC][1];
  assign adc_en_o     = p_taps[PATH_ADC][2];
  assign dac_ready_o  = ready_q[PATH_DAC];
  assign adc_ready_o  = ready_q[PATH_ADC];

  assign state_vec = {sh_lvl, p_lvl[PATH_DAC], p_lvl[PATH_ADC]};

  assert_dac_deps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_en_o |-> (if_gate_o && sysclk_en_o && dac_gate_o));
  assert_adc_deps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_en_o |-> (if_gate_o && sysclk_en_o && adc_gate_o));
  assert_dac_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_en_o |=> dac_ready_o);
  assert_adc_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_en_o |=> !adc_ready_o);
  assert_step_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_vec != $past(state_vec)) |=> $stable(state_vec));
  assert_shared_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p_empty[PATH_DAC] || !p_empty[PATH_ADC]) |-> sysclk_en_o);
  assert_reverse_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(if_gate_o) |-> (&p_empty));
endmodule

// File: tb/codec_pwr_seq_bench.sv
module codec_pwr_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       play = 1'b0;
  logic       cap = 1'b0;
  logic [7:0] wait_cyc = 8'd2;
  logic       sysclk_src, ifclk_en, pll_src, if_rst_n, if_gate, sysclk_en;
  logic       dac_rst_n, dac_gate, dac_en, adc_rst_n, adc_gate, adc_en;
  logic       dac_ready, adc_ready;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  codec_pwr_seq u_codec_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .play_req_i(play), .cap_req_i(cap),
    .step_wait_i(wait_cyc),
    .sysclk_src_o(sysclk_src), .ifclk_en_o(ifclk_en), .pll_src_o(pll_src),
    .if_rst_no(if_rst_n), .if_gate_o(if_gate), .sysclk_en_o(sysclk_en),
    .dac_rst_no(dac_rst_n), .dac_gate_o(dac_gate), .dac_en_o(dac_en),
    .adc_rst_no(adc_rst_n), .adc_gate_o(adc_gate), .adc_en_o(adc_en),
    .dac_ready_o(dac_ready), .adc_ready_o(adc_ready)
  );

  function automatic logic [13:0] actual();
    return {sysclk_src, ifclk_en, pll_src, if_rst_n, if_gate, sysclk_en,
            dac_rst_n, dac_gate, dac_en, adc_rst_n, adc_gate, adc_en,
            dac_ready, adc_ready};
  endfunction

  function automatic logic [13:0] expect_vec(int s, int d, int a, bit dr, bit ar);
    return {!(s >= 1), s >= 2, s >= 3, s >= 4, s >= 5, s >= 6,
            d >= 1, d >= 2, d >= 3, a >= 1, a >= 2, a >= 3, dr, ar};
  endfunction

  function automatic int clampi(int v, int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  task automatic check(string tag, logic [13:0] exp);
    n_chk++;
    if (actual() !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, actual(), exp);
    end
  endtask

  // Requests already changed at a falling edge; sample after each later falling edge.
  task automatic ramp(string tag, int w, bit up, int s_n, int d_n, int a_n,
                      int s0, int d0, int a0);
    int weff, tot, k, ks, kd, ka, s, d, a;
    bit pdr, par;
    weff = (w < 2) ? 2 : w;
    tot  = s_n + d_n + a_n;
    pdr  = (d0 == 3);
    par  = (a0 == 3);
    for (int n = 0; n <= tot * weff + 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      k = n / weff + 1;
      if (k > tot) k = tot;
      if (up) begin
        ks = clampi(k, s_n);
        kd = clampi(k - s_n, d_n);
        ka = clampi(k - s_n - d_n, a_n);
        s = s0 + ks; d = d0 + kd; a = a0 + ka;
      end else begin
        kd = clampi(k, d_n);
        ka = clampi(k - d_n, a_n);
        ks = clampi(k - d_n - a_n, s_n);
        s = s0 - ks; d = d0 - kd; a = a0 - ka;
      end
      check(tag, expect_vec(s, d, a, pdr, par));
      pdr = (d == 3);
      par = (a == 3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", expect_vec(0, 0, 0, 0, 0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", expect_vec(0, 0, 0, 0, 0));

    for (int wi = 0; wi < 6; wi++) begin
      wait_cyc = 8'(wi);
      // playback alone
      play = 1'b1;
      ramp("R2 R3 R5 R6 R7 play up", wi, 1, 6, 3, 0, 0, 0, 0);
      play = 1'b0;
      ramp("R8 R5 R7 play down", wi, 0, 6, 3, 0, 6, 3, 0);
      // capture alone
      cap = 1'b1;
      ramp("R2 R4 R5 R6 R7 cap up", wi, 1, 6, 0, 3, 0, 0, 0);
      cap = 1'b0;
      ramp("R8 R5 cap down", wi, 0, 6, 0, 3, 6, 0, 3);
      // both together, DAC first
      play = 1'b1; cap = 1'b1;
      ramp("R4 R6 R7 both up", wi, 1, 6, 3, 3, 0, 0, 0);
      cap = 1'b0;
      ramp("R9 drop capture", wi, 0, 0, 0, 3, 6, 3, 3);
      cap = 1'b1;
      ramp("R4 add capture", wi, 1, 0, 0, 3, 6, 3, 0);
      play = 1'b0;
      ramp("R9 drop playback", wi, 0, 0, 3, 0, 6, 3, 3);
      cap = 1'b0;
      ramp("R8 cap down last", wi, 0, 6, 0, 3, 6, 0, 3);
    end

    // reversal: W=3, playback dropped then requested again mid-descent
    wait_cyc = 8'd3;
    play = 1'b1;
    ramp("R3 play up for abort", 3, 1, 6, 3, 0, 0, 0, 0);
    play = 1'b0;
    @(posedge clk); @(negedge clk);           // n=0: dac_en off, ready still high
    check("R10 first down step", expect_vec(6, 2, 0, 1, 0));
    play = 1'b1;
    @(posedge clk); @(negedge clk);           // n=1
    check("R10 waiting slot", expect_vec(6, 2, 0, 0, 0));
    @(posedge clk); @(negedge clk);           // n=2
    check("R10 still waiting", expect_vec(6, 2, 0, 0, 0));
    @(posedge clk); @(negedge clk);           // n=3: turned around
    check("R10 enable restored", expect_vec(6, 3, 0, 0, 0));
    @(posedge clk); @(negedge clk);           // n=4
    check("R10 R7 ready restored", expect_vec(6, 3, 0, 1, 0));
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      check("R10 holds up", expect_vec(6, 3, 0, 1, 0));
    end
    play = 1'b0;
    ramp("R8 final down", 3, 0, 6, 3, 0, 6, 3, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule